// File: doc/BRIEF.md
# Multiword Arithmetic Operation Control Registers

This block is the host-side register bank and launch controller for a coprocessor that works on long integers held in a shared word memory. A host writes word pointers for up to four operand vectors, two operand lengths, a bit-shift count and a function word through a simple 32-bit write port. Setting the run bit in the function word, together with one operation select, hands the operation to an external arithmetic engine with a one-cycle start pulse. The engine's single-cycle done pulse ends the operation. Run then clears, and the compare flags and the two most-significant-word reports from the engine become readable.

Pointers and lengths are double-buffered. The host sees and writes a shadow copy. The engine is driven from an active copy that is loaded only when an operation launches, so the next operation can be prepared while the current one runs. The shift count and the operation-select bits are frozen while the engine is busy. A stall-result control lets the host keep the previous results readable: a finished operation is parked, with run still set, until the host clears the stall bit.

Control is a five-state machine:
- BOOT: run reads 1 for a fixed number of cycles after reset.
- IDLE: run reads 0.
- LAUNCH: start pulse and selection of the operation.
- BUSY: waiting for done.
- HOLD: result parked under stall.

Its transitions are:
- BOOT to IDLE when the boot count expires.
- IDLE to LAUNCH on a valid run write.
- LAUNCH to BUSY unconditionally.
- BUSY to IDLE on done with stall clear.
- BUSY to HOLD on done with stall set.
- HOLD to IDLE once stall reads 0.

Top module: `bignum_ctl_regs`

## Requirements
- R1: Word addresses 0..3 hold operand pointers A..D, 11 bits each. Bit 0 of a stored pointer is always 0, whatever was written, both on readback and on the engine pointer outputs.
- R2: Address 4 and address 5 hold lengths A and B (9 bits each), and address 6 holds the shift count (5 bits). Bits above a field's width are dropped on write and read back as 0.
- R3: In IDLE, a write to the function word (address 7) with bit 15 (run) set and at least one operation bit set causes the following. eng_start pulses for exactly one cycle. The launch copies the shadow pointers and lengths to the engine outputs. Run reads 1 until completion. The operation bits are 0 multiply, 1 add/subtract, 4 add, 5 subtract, 6 right shift, 7 left shift, 8 divide, 9 modulo, 10 compare and 11 copy.
- R4: irq is always the complement of the run bit, including during the boot window.
- R5: With stall (function bit 24) clear, the clock edge that samples eng_done clears run. The same edge loads the engine's compare flags (address 8, bits 2:0), word report (address 9) and remainder report (address 10).
- R6: Pointer and length writes made while an operation runs update the readback at once. They do not change the engine outputs until the next launch.
- R7: With stall set, done leaves run at 1 and the result registers unchanged. In the cycle after stall is written back to 0, the parked results load and run clears. This also holds when the stall-clearing write lands in the same cycle as done.
- R8: While run is 1, writes to function bits 11:0, to the run bit and to the shift count have no effect on readback or on the engine outputs.
- R9: If several operation bits are set at launch, eng_op carries only the lowest-numbered one. op_err is set one cycle after that launch, and it holds until the next launch, which clears it when that launch selects a single operation.
- R10: A run write whose operation bits are all zero (bit 3, the most-significant-one report, does not count as an operation) starts nothing. eng_start stays low and run stays 0.
- R11: For BOOT_CYCLES cycles after reset release, run reads 1. Afterwards it reads 0. All pointers, lengths, shift and results reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | AW (4) | word address for write and readback |
| reg_wdata | input | DW (32) | write data |
| reg_rdata | output | DW (32) | combinational readback of the addressed register |
| eng_start | output | 1 | one-cycle launch pulse |
| eng_op | output | 12 | one-hot selected operation, bit positions as the function word |
| eng_msone | output | 1 | most-significant-one report request (function bit 3) |
| eng_aptr | output | PTR_W (11) | active pointer A |
| eng_bptr | output | PTR_W (11) | active pointer B |
| eng_cptr | output | PTR_W (11) | active pointer C |
| eng_dptr | output | PTR_W (11) | active pointer D |
| eng_alen | output | LEN_W (9) | active length A |
| eng_blen | output | LEN_W (9) | active length B |
| eng_shift | output | SHF_W (5) | shift count |
| eng_done | input | 1 | one-cycle completion pulse from the engine |
| eng_cmp | input | CMP_W (3) | compare flags from the engine |
| eng_msw | input | MSW_W (16) | result most-significant-word report |
| eng_divmsw | input | MSW_W (16) | remainder most-significant-word report |
| irq | output | 1 | complement of run |
| op_err | output | 1 | several operations were selected at the last launch |

## Verification
Two events can share a cycle: the engine's done pulse arriving in BUSY, and the host's write that clears the stall bit. The bench watches eng_done at the falling edge and issues the stall-clearing write in that very cycle. The edge that samples done therefore still sees stall set and parks the result. The run bit must read 1 just after that edge and 0 one edge later, with the new compare and word reports visible. Any loss or early release of the parked result shows up as stale status or a run bit that clears one cycle early.

// File: rtl/bignum_ctl_pkg.sv
package bignum_ctl_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_LAUNCH,
        ST_BUSY,
        ST_HOLD
    } ctl_state_e;

    // function word layout
    localparam int FOP_W     = 12;
    localparam int RUN_BIT   = 15;
    localparam int STALL_BIT = 24;
    localparam int MSONE_BIT = 3;
    // bits that select an operation (bit 2 reserved, bit 3 is a modifier)
    localparam logic [FOP_W-1:0] OP_MASK = 12'b1111_1111_0011;

    // word addresses
    localparam int A_PTR0  = 0;
    localparam int A_LEN0  = 4;
    localparam int A_SHIFT = 6;
    localparam int A_FUNC  = 7;
    localparam int A_CMP   = 8;
    localparam int A_MSW   = 9;
    localparam int A_DIV   = 10;

endpackage

// File: rtl/bn_op_select.sv
module bn_op_select #(
    parameter int FW = 12
) (
    input  logic [FW-1:0] func_bits,
    input  logic [FW-1:0] op_mask,
    output logic [FW-1:0] op_onehot,
    output logic          any_sel,
    output logic          multi_sel
);
    logic [FW-1:0] cand;
    logic          found;
    int            hits;

    assign cand = func_bits & op_mask;

    always_comb begin
        op_onehot = '0;
        found     = 1'b0;
        hits      = 0;
        for (int i = 0; i < FW; i++) begin
            if (cand[i]) begin
                hits = hits + 1;
                if (!found) begin
                    op_onehot[i] = 1'b1;
                    found        = 1'b1;
                end
            end
        end
        any_sel   = found;
        multi_sel = (hits > 1);
    end
endmodule

// File: rtl/bn_shadow_bank.sv
module bn_shadow_bank #(
    parameter int N      = 4,
    parameter int W      = 11,
    parameter bit ALIGN0 = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr_en,
    input  logic [W-1:0]        wdata,
    input  logic                load,
    output logic [N-1:0][W-1:0] shadow_o,
    output logic [N-1:0][W-1:0] active_o
);
    logic [W-1:0] wval;

    generate
        if (ALIGN0) begin : g_align
            assign wval = {wdata[W-1:1], 1'b0};
        end else begin : g_plain
            assign wval = wdata;
        end
    endgenerate

    generate
        for (genvar i = 0; i < N; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_o[i] <= '0;
                end else if (wr_en[i]) begin
                    shadow_o[i] <= wval;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    active_o[i] <= '0;
                end else if (load) begin
                    active_o[i] <= shadow_o[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bn_result_hold.sv
module bn_result_hold #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] res_in,
    input  logic         take_now,
    input  logic         park,
    input  logic         release_i,
    output logic [W-1:0] res_out
);
    logic [W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (park) begin
            pend_q <= res_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '0;
        end else if (take_now) begin
            res_out <= res_in;
        end else if (release_i) begin
            res_out <= pend_q;
        end
    end
endmodule

// File: rtl/bignum_ctl_regs.sv
module bignum_ctl_regs
    import bignum_ctl_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 4,
    parameter int PTR_W       = 11,
    parameter int LEN_W       = 9,
    parameter int SHF_W       = 5,
    parameter int CMP_W       = 3,
    parameter int MSW_W       = 16,
    parameter int BOOT_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             eng_start,
    output logic [11:0]      eng_op,
    output logic             eng_msone,
    output logic [PTR_W-1:0] eng_aptr,
    output logic [PTR_W-1:0] eng_bptr,
    output logic [PTR_W-1:0] eng_cptr,
    output logic [PTR_W-1:0] eng_dptr,
    output logic [LEN_W-1:0] eng_alen,
    output logic [LEN_W-1:0] eng_blen,
    output logic [SHF_W-1:0] eng_shift,
    input  logic             eng_done,
    input  logic [CMP_W-1:0] eng_cmp,
    input  logic [MSW_W-1:0] eng_msw,
    input  logic [MSW_W-1:0] eng_divmsw,
    output logic             irq,
    output logic             op_err
);
    localparam int NPTR   = 4;
    localparam int NLEN   = 2;
    localparam int RES_W  = CMP_W + 2 * MSW_W;
    localparam int BCNT_W = $clog2(BOOT_CYCLES + 1);
    localparam logic [BCNT_W-1:0] BOOT_LAST = BCNT_W'(BOOT_CYCLES - 1);

    ctl_state_e state_q, state_d;
    logic [BCNT_W-1:0] boot_cnt_q;

    logic [FOP_W-1:0] func_raw_q;
    logic             stall_q;
    logic [SHF_W-1:0] shift_q;
    logic             op_err_q;

    logic             run;
    logic             go_launch;
    logic             res_take, res_park, res_release;

    logic [NPTR-1:0]  ptr_wr;
    logic [NLEN-1:0]  len_wr;
    logic             shift_wr, func_wr;

    logic [NPTR-1:0][PTR_W-1:0] ptr_shadow, ptr_active;
    logic [NLEN-1:0][LEN_W-1:0] len_shadow, len_active;

    logic [FOP_W-1:0] wr_onehot, raw_onehot;
    logic             wr_any, wr_multi, raw_any, raw_multi;

    logic [RES_W-1:0] res_vis;
    logic [CMP_W-1:0] cmp_vis;
    logic [MSW_W-1:0] msw_vis, div_vis;

    // ---------------- write decode ----------------
    generate
        for (genvar i = 0; i < NPTR; i++) begin : g_ptr_dec
            assign ptr_wr[i] = reg_we && (reg_addr == AW'(A_PTR0 + i));
        end
        for (genvar j = 0; j < NLEN; j++) begin : g_len_dec
            assign len_wr[j] = reg_we && (reg_addr == AW'(A_LEN0 + j));
        end
    endgenerate
    assign shift_wr = reg_we && (reg_addr == AW'(A_SHIFT));
    assign func_wr  = reg_we && (reg_addr == AW'(A_FUNC));

    // ---------------- operation select ----------------
    bn_op_select #(.FW(FOP_W)) u_sel_wr (
        .func_bits (reg_wdata[FOP_W-1:0]),
        .op_mask   (OP_MASK),
        .op_onehot (wr_onehot),
        .any_sel   (wr_any),
        .multi_sel (wr_multi)
    );

    bn_op_select #(.FW(FOP_W)) u_sel_raw (
        .func_bits (func_raw_q),
        .op_mask   (OP_MASK),
        .op_onehot (raw_onehot),
        .any_sel   (raw_any),
        .multi_sel (raw_multi)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_cnt_q <= '0;
        end else if (state_q == ST_BOOT) begin
            boot_cnt_q <= boot_cnt_q + 1'b1;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   if (boot_cnt_q == BOOT_LAST) state_d = ST_IDLE;
            ST_IDLE:   if (func_wr && reg_wdata[RUN_BIT] && wr_any) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_BUSY;
            ST_BUSY:   if (eng_done) state_d = stall_q ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (!stall_q) state_d = ST_IDLE;
            default:   state_d = ST_BOOT;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        run         = 1'b1;
        eng_start   = 1'b0;
        go_launch   = 1'b0;
        res_take    = 1'b0;
        res_park    = 1'b0;
        res_release = 1'b0;
        unique case (state_q)
            ST_BOOT:   run = 1'b1;
            ST_IDLE: begin
                run       = 1'b0;
                go_launch = (state_d == ST_LAUNCH);
            end
            ST_LAUNCH: eng_start = 1'b1;
            ST_BUSY: begin
                res_take = eng_done && !stall_q;
                res_park = eng_done && stall_q;
            end
            ST_HOLD:   res_release = !stall_q;
            default:   run = 1'b1;
        endcase
    end

    // ---------------- function / shift registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_raw_q <= '0;
        end else if (func_wr && !run) begin
            func_raw_q <= reg_wdata[FOP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
        end else if (func_wr) begin
            stall_q <= reg_wdata[STALL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (shift_wr && !run) begin
            shift_q <= reg_wdata[SHF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_err_q <= 1'b0;
        end else if (state_q == ST_LAUNCH) begin
            op_err_q <= raw_multi;
        end
    end

    // ---------------- double-buffered operand fields ----------------
    bn_shadow_bank #(.N(NPTR), .W(PTR_W), .ALIGN0(1'b1)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .wdata    (reg_wdata[PTR_W-1:0]),
        .load     (go_launch),
        .shadow_o (ptr_shadow),
        .active_o (ptr_active)
    );

    bn_shadow_bank #(.N(NLEN), .W(LEN_W), .ALIGN0(1'b0)) u_lens (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (len_wr),
        .wdata    (reg_wdata[LEN_W-1:0]),
        .load     (go_launch),
        .shadow_o (len_shadow),
        .active_o (len_active)
    );

    // ---------------- result status ----------------
    bn_result_hold #(.W(RES_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_in    ({eng_cmp, eng_msw, eng_divmsw}),
        .take_now  (res_take),
        .park      (res_park),
        .release_i (res_release),
        .res_out   (res_vis)
    );
    assign {cmp_vis, msw_vis, div_vis} = res_vis;

    // ---------------- readback ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < AW'(A_LEN0)) begin
            reg_rdata = DW'(ptr_shadow[reg_addr[1:0]]);
        end else if (reg_addr == AW'(A_LEN0) || reg_addr == AW'(A_LEN0 + 1)) begin
            reg_rdata = DW'(len_shadow[reg_addr[0]]);
        end else if (reg_addr == AW'(A_SHIFT)) begin
            reg_rdata = DW'(shift_q);
        end else if (reg_addr == AW'(A_FUNC)) begin
            reg_rdata                = DW'(func_raw_q);
            reg_rdata[RUN_BIT]       = run;
            reg_rdata[STALL_BIT]     = stall_q;
        end else if (reg_addr == AW'(A_CMP)) begin
            reg_rdata = DW'(cmp_vis);
        end else if (reg_addr == AW'(A_MSW)) begin
            reg_rdata = DW'(msw_vis);
        end else if (reg_addr == AW'(A_DIV)) begin
            reg_rdata = DW'(div_vis);
        end
    end

    // ---------------- engine side ----------------
    assign eng_op    = raw_any ? raw_onehot : '0;
    assign eng_msone = func_raw_q[MSONE_BIT];
    assign eng_aptr  = ptr_active[0];
    assign eng_bptr  = ptr_active[1];
    assign eng_cptr  = ptr_active[2];
    assign eng_dptr  = ptr_active[3];
    assign eng_alen  = len_active[0];
    assign eng_blen  = len_active[1];
    assign eng_shift = shift_q;
    assign irq       = !run;
    assign op_err    = op_err_q;

endmodule

// File: rtl/bignum_ctl_regs_chk.sv
module bignum_ctl_regs_chk #(
    parameter int PTR_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_start,
    input logic             eng_done,
    input logic             irq,
    input logic             stall_q,
    input logic [11:0]      eng_op,
    input logic [PTR_W-1:0] eng_aptr,
    input logic [PTR_W-1:0] eng_bptr
);
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_irq_low_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !irq);

    assert_stall_keeps_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && stall_q && !irq) |=> !irq);

    assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_op));

    assert_active_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |=> $stable(eng_aptr) && $stable(eng_bptr));

    assert_ptr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_aptr[0] && !eng_bptr[0]);
endmodule

bind bignum_ctl_regs bignum_ctl_regs_chk #(.PTR_W(PTR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .irq       (irq),
    .stall_q   (stall_q),
    .eng_op    (eng_op),
    .eng_aptr  (eng_aptr),
    .eng_bptr  (eng_bptr)
);

// File: tb/bignum_ctl_regs_tb_top.sv
module bignum_ctl_regs_tb_top;
    localparam int BOOT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_start, eng_msone, irq, op_err;
    logic [11:0] eng_op;
    logic [10:0] eng_aptr, eng_bptr, eng_cptr, eng_dptr;
    logic [8:0]  eng_alen, eng_blen;
    logic [4:0]  eng_shift;
    logic        eng_done = 1'b0;
    logic [2:0]  eng_cmp = '0;
    logic [15:0] eng_msw = '0, eng_divmsw = '0;

    int n_chk = 0, n_bad = 0, starts = 0, eng_dly = 1, cnt = 0, cyc = 0;

    always #10 clk = ~clk;

    bignum_ctl_regs #(.BOOT_CYCLES(BOOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_op(eng_op), .eng_msone(eng_msone), .eng_aptr(eng_aptr),
        .eng_bptr(eng_bptr), .eng_cptr(eng_cptr), .eng_dptr(eng_dptr),
        .eng_alen(eng_alen), .eng_blen(eng_blen), .eng_shift(eng_shift),
        .eng_done(eng_done), .eng_cmp(eng_cmp), .eng_msw(eng_msw),
        .eng_divmsw(eng_divmsw), .irq(irq), .op_err(op_err)
    );

    // engine stub: done pulse eng_dly cycles after the start is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            eng_done <= 1'b0;
        end else begin
            eng_done <= 1'b0;
            if (eng_start) begin
                cnt <= eng_dly;
                starts <= starts + 1;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) eng_done <= 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 300; i++) begin
            if (irq) return;
            @(negedge clk);
        end
        chk(1'b0, tag, {31'b0, irq}, 32'h1);
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 300; i++) begin
            if (eng_done) return;
            @(negedge clk);
        end
        chk(1'b0, tag, {31'b0, eng_done}, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(4'd7, v);
        chk_eq("R11 run high after reset", {31'b0, v[15]}, 32'h1);
        chk_eq("R4 irq low during boot", {31'b0, irq}, 32'h0);
        rd(4'd0, v);
        chk_eq("R11 pointer reset", v, 32'h0);
        rd(4'd9, v);
        chk_eq("R11 result reset", v, 32'h0);
        repeat (BOOT + 1) @(negedge clk);
        rd(4'd7, v);
        chk_eq("R11 run clears after boot", {31'b0, v[15]}, 32'h0);
        chk_eq("R4 irq high when idle", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_F7FF);
        rd(4'd0, v);
        chk_eq("R1 pointer A bit0 dropped", v, 32'h7FE);
        wr(4'd3, 32'h0000_0123);
        rd(4'd3, v);
        chk_eq("R1 pointer D aligned", v, 32'h122);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, v);
        chk_eq("R2 length A width", v, 32'h1FF);
        wr(4'd6, 32'h0000_00FF);
        rd(4'd6, v);
        chk_eq("R2 shift width", v, 32'h1F);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int s0;
        s0 = starts;
        eng_dly = 3; eng_cmp = 3'b100; eng_msw = 16'h0123; eng_divmsw = 16'h8000;
        wr(4'd0, 32'h40);
        wr(4'd7, 32'h0000_8010);
        rd(4'd7, v);
        chk_eq("R3 run reads 1 after start", {31'b0, v[15]}, 32'h1);
        chk_eq("R4 irq low while running", {31'b0, irq}, 32'h0);
        chk_eq("R3 eng_op add", {20'b0, eng_op}, 32'h010);
        @(negedge clk);
        chk_eq("R3 launched pointer", {21'b0, eng_aptr}, 32'h40);
        wait_done("R5 done timeout");
        chk_eq("R5 run still set in done cycle", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk_eq("R5 run clears on done edge", {31'b0, irq}, 32'h1);
        rd(4'd8, v);
        chk_eq("R5 compare flags", v, 32'h4);
        rd(4'd9, v);
        chk_eq("R5 word report", v, 32'h0123);
        rd(4'd10, v);
        chk_eq("R5 remainder report", v, 32'h8000);
        chk_eq("R3 exactly one start", starts - s0, 32'd1);
    endtask

    task automatic t_shadow();
        logic [31:0] v;
        eng_dly = 10;
        wr(4'd0, 32'h10);
        wr(4'd5, 32'h3);
        wr(4'd7, 32'h0000_8010);
        wr(4'd0, 32'h20);
        wr(4'd5, 32'h5);
        rd(4'd0, v);
        chk_eq("R6 shadow readback new", v, 32'h20);
        chk_eq("R6 active pointer kept", {21'b0, eng_aptr}, 32'h10);
        chk_eq("R6 active length kept", {23'b0, eng_blen}, 32'h3);
        wait_idle("R6 idle timeout");
        chk_eq("R6 active pointer after done", {21'b0, eng_aptr}, 32'h10);
        wr(4'd7, 32'h0000_8010);
        chk_eq("R6 new pointer on next start", {21'b0, eng_aptr}, 32'h20);
        chk_eq("R6 new length on next start", {23'b0, eng_blen}, 32'h5);
        wait_idle("R6 idle timeout");
    endtask

    task automatic t_lock();
        logic [31:0] v;
        eng_dly = 10;
        wr(4'd6, 32'h3);
        wr(4'd7, 32'h0000_8020);
        wr(4'd6, 32'h7);
        wr(4'd7, 32'h0000_0001);
        rd(4'd7, v);
        chk_eq("R8 op bits locked", {20'b0, v[11:0]}, 32'h020);
        chk_eq("R8 run write ignored", {31'b0, v[15]}, 32'h1);
        rd(4'd6, v);
        chk_eq("R8 shift locked", v, 32'h3);
        chk_eq("R8 eng_op unchanged", {20'b0, eng_op}, 32'h020);
        wait_idle("R8 idle timeout");
    endtask

    task automatic t_stall();
        logic [31:0] v;
        eng_dly = 2; eng_cmp = 3'b001; eng_msw = 16'h00AA; eng_divmsw = 16'h0055;
        wr(4'd7, 32'h0100_8001);
        repeat (20) @(negedge clk);
        chk_eq("R7 run held under stall", {31'b0, irq}, 32'h0);
        rd(4'd8, v);
        chk_eq("R7 status frozen", v, 32'h4);
        wr(4'd7, 32'h0000_0000);
        chk_eq("R7 run still set after release write", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk_eq("R7 run clears cycle after release", {31'b0, irq}, 32'h1);
        rd(4'd9, v);
        chk_eq("R7 parked word report loaded", v, 32'h00AA);
        rd(4'd8, v);
        chk_eq("R7 parked compare loaded", v, 32'h1);
    endtask

    task automatic t_coincide();
        logic [31:0] v;
        eng_dly = 4; eng_cmp = 3'b010; eng_msw = 16'h0777; eng_divmsw = 16'h0011;
        wr(4'd7, 32'h0100_8001);
        wait_done("R7 coincide done timeout");
        wr(4'd7, 32'h0000_0000);
        chk_eq("R7 coincide run held", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk_eq("R7 coincide run clears", {31'b0, irq}, 32'h1);
        rd(4'd9, v);
        chk_eq("R7 coincide word report", v, 32'h0777);
        rd(4'd8, v);
        chk_eq("R7 coincide compare", v, 32'h2);
    endtask

    task automatic t_prio();
        eng_dly = 3;
        wr(4'd7, 32'h0000_8130);
        chk_eq("R9 lowest op wins", {20'b0, eng_op}, 32'h010);
        @(negedge clk);
        chk_eq("R9 op_err raised", {31'b0, op_err}, 32'h1);
        wait_idle("R9 idle timeout");
        chk_eq("R9 op_err holds", {31'b0, op_err}, 32'h1);
        wr(4'd7, 32'h0000_8001);
        @(negedge clk);
        chk_eq("R9 op_err cleared", {31'b0, op_err}, 32'h0);
        chk_eq("R9 single op", {20'b0, eng_op}, 32'h001);
        wait_idle("R9 idle timeout");
    endtask

    task automatic t_noop();
        logic [31:0] v;
        int s0;
        s0 = starts;
        wr(4'd7, 32'h0000_8008);
        @(negedge clk);
        rd(4'd7, v);
        chk_eq("R10 run stays 0 with modifier only", {31'b0, v[15]}, 32'h0);
        chk_eq("R10 irq stays high", {31'b0, irq}, 32'h1);
        wr(4'd7, 32'h0000_8000);
        @(negedge clk);
        chk_eq("R10 no start issued", starts - s0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_basic();
        t_shadow();
        t_lock();
        t_stall();
        t_coincide();
        t_prio();
        t_noop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule